// File: doc/BRIEF.md
# Serial Port Interrupt Status and Mask Unit

This unit produces the single interrupt line of a synchronous serial port from four sources. Two of them are levels derived from the FIFO fill counts. The receive source is active when enough words are waiting. The transmit source is active when room is running low. The other two are sticky flags for receive overrun and receive timeout. Detectors elsewhere in the port raise these flags with one-cycle pulses.

Software sees the unit through a small register port with a two-bit address. It can write and read back an enable mask, and read the raw status and the masked status. A write-one-to-clear register drops the sticky flags. The level-derived sources cannot be cleared from there. They follow the FIFO counts only. The combined interrupt output is registered.

Top module: `spi_irq_unit`

## Requirements
- R1: Status bits are placed as: bit 0 overrun, bit 1 timeout, bit 2 receive level, bit 3 transmit level. Register addresses are: 0 mask (read/write), 1 raw status (read), 2 masked status (read), 3 clear (write, reads as 0).
- R2: Raw bit 2 is 1 exactly when the receive level input is 4 or more.
- R3: Raw bit 3 is 1 exactly when the transmit level input is 4 or less.
- R4: After reset the mask reads 0, both sticky bits are 0, and with both levels at 0 the raw status reads 4'b1000.
- R5: A pulse on the overrun input sets raw bit 0 from the next cycle. A pulse on the timeout input does the same for raw bit 1. Each bit stays set until it is cleared.
- R6: A write to address 3 clears raw bit 0 and/or raw bit 1 at the next edge, for each data bit that is 1. Data bits that are 0, and data bits 2 and 3, change nothing.
- R7: When an event pulse and a clear of the same bit arrive in one cycle, the bit ends up set.
- R8: A mask write takes effect at the next edge. Address 2 reads the mask AND the raw status.
- R9: The interrupt output equals the OR of (mask AND raw status) as it stood in the previous cycle. It is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxLevel | input | LVL_W | Receive FIFO fill count |
| txLevel | input | LVL_W | Transmit FIFO fill count |
| overrunPulse | input | 1 | One-cycle receive overrun event |
| timeoutPulse | input | 1 | One-cycle receive timeout event |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| regWrData | input | 4 | Register write data |
| regRdData | output | 4 | Register read data, driven combinationally from regAddr |
| irqOut | output | 1 | Combined registered interrupt |

## Verification
Two functions can collide in one cycle: a sticky-bit event pulse and a software clear of the same bit. The bench provokes this on purpose in directed steps for both the overrun and the timeout bit. Random traffic then fires pulses and clear writes independently, so the collision also recurs many times. The result is judged by reading the raw status in the following cycle against a model in which set wins over clear.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int NUM_SRC = 4;
  localparam int NUM_STICKY = 2;
  localparam int BIT_OVR = 0;
  localparam int BIT_TMO = 1;
  localparam int BIT_RX = 2;
  localparam int BIT_TX = 3;

  typedef enum logic [1:0] {
    SEL_MASK   = 2'd0,
    SEL_RAW    = 2'd1,
    SEL_MASKED = 2'd2,
    SEL_CLEAR  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic                maskWr;
    logic                clrWr;
    logic [NUM_SRC-1:0]  wrData;
    regSel_e             rdSel;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_unit_pkg::*;
(
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  output ctrlStrobes_t       strobes
);
  regSel_e sel;

  always_comb begin
    sel = regSel_e'(regAddr);
    strobes.rdSel  = sel;
    strobes.wrData = regWrData;
    strobes.maskWr = regWrEn && (sel == SEL_MASK);
    strobes.clrWr  = regWrEn && (sel == SEL_CLEAR);
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_unit_pkg::*;
#(
  parameter int LVL_W     = 4,
  parameter int RX_THRESH = 4,
  parameter int TX_THRESH = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [LVL_W-1:0]   rxLevel,
  input  logic [LVL_W-1:0]   txLevel,
  input  logic               overrunPulse,
  input  logic               timeoutPulse,
  output logic [NUM_SRC-1:0] rawStat,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] regRdData,
  output logic               irqOut
);
  localparam logic [LVL_W-1:0] RX_LIM = LVL_W'(RX_THRESH);
  localparam logic [LVL_W-1:0] TX_LIM = LVL_W'(TX_THRESH);

  logic [NUM_STICKY-1:0] eventIn;
  logic [NUM_STICKY-1:0] stickyQ;
  logic                  rxHigh;
  logic                  txLow;

  assign eventIn[BIT_OVR] = overrunPulse;
  assign eventIn[BIT_TMO] = timeoutPulse;

  genvar g;
  generate
    for (g = 0; g < NUM_STICKY; g++) begin : g_sticky
      always_ff @(posedge clk) begin
        if (!rstN) begin
          stickyQ[g] <= 1'b0;
        end else if (eventIn[g]) begin
          stickyQ[g] <= 1'b1;
        end else if (strobes.clrWr && strobes.wrData[g]) begin
          stickyQ[g] <= 1'b0;
        end
      end
    end
  endgenerate

  assign rxHigh = (rxLevel >= RX_LIM);
  assign txLow  = (txLevel <= TX_LIM);

  always_comb begin
    rawStat = '0;
    rawStat[NUM_STICKY-1:0] = stickyQ;
    rawStat[BIT_RX] = rxHigh;
    rawStat[BIT_TX] = txLow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskQ  <= '0;
      irqOut <= 1'b0;
    end else begin
      if (strobes.maskWr) maskQ <= strobes.wrData;
      irqOut <= |(rawStat & maskQ);
    end
  end

  always_comb begin
    case (strobes.rdSel)
      SEL_MASK:   regRdData = maskQ;
      SEL_RAW:    regRdData = rawStat;
      SEL_MASKED: regRdData = maskQ & rawStat;
      default:    regRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
  import irq_unit_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int RX_THRESH  = 4,
  parameter int TX_THRESH  = 4,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LVL_W-1:0] rxLevel,
  input  logic [LVL_W-1:0] txLevel,
  input  logic             overrunPulse,
  input  logic             timeoutPulse,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [3:0]       regWrData,
  output logic [3:0]       regRdData,
  output logic             irqOut
);
  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] rawStat;
  logic [NUM_SRC-1:0] maskQ;

  irq_ctrl i_ctrl (
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .strobes  (strobes)
  );

  irq_datapath #(
    .LVL_W    (LVL_W),
    .RX_THRESH(RX_THRESH),
    .TX_THRESH(TX_THRESH)
  ) i_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .rxLevel     (rxLevel),
    .txLevel     (txLevel),
    .overrunPulse(overrunPulse),
    .timeoutPulse(timeoutPulse),
    .rawStat     (rawStat),
    .maskQ       (maskQ),
    .regRdData   (regRdData),
    .irqOut      (irqOut)
  );
endmodule

// File: rtl/spi_irq_unit_chk.sv
module spi_irq_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       overrunPulse,
  input logic       timeoutPulse,
  input logic       regWrEn,
  input logic [1:0] regAddr,
  input logic [3:0] regWrData,
  input logic [3:0] regRdData,
  input logic       irqOut,
  input logic [3:0] rawStat,
  input logic [3:0] maskQ
);
  logic clrOvr;
  logic clrTmo;
  assign clrOvr = regWrEn && (regAddr == 2'd3) && regWrData[0];
  assign clrTmo = regWrEn && (regAddr == 2'd3) && regWrData[1];

  // R5 / R7: an event always leaves its bit set
  p_ovr_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    overrunPulse |=> rawStat[0]);
  p_tmo_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> rawStat[1]);
  // R5: held until cleared
  p_ovr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rawStat[0] && !clrOvr) |=> rawStat[0]);
  // R6: clear without a competing event drops the bit
  p_ovr_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrOvr && !overrunPulse) |=> !rawStat[0]);
  p_tmo_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrTmo && !timeoutPulse) |=> !rawStat[1]);
  // R9: registered combined interrupt
  p_irq_on_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|(rawStat & maskQ)) |=> irqOut);
  p_irq_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(|(rawStat & maskQ)) |=> !irqOut);
  // R8: masked view
  p_masked_view_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdData == (maskQ & rawStat)));
endmodule

bind spi_irq_unit spi_irq_unit_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .overrunPulse(overrunPulse),
  .timeoutPulse(timeoutPulse),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regWrData   (regWrData),
  .regRdData   (regRdData),
  .irqOut      (irqOut),
  .rawStat     (rawStat),
  .maskQ       (maskQ)
);

// File: tb/test_spi_irq_unit.sv
module test_spi_irq_unit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] rxLevel = '0;
  logic [3:0] txLevel = '0;
  logic       overrunPulse = 1'b0;
  logic       timeoutPulse = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [3:0] regWrData = '0;
  logic [3:0] regRdData;
  logic       irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [1:0] mSticky = '0;
  logic [3:0] mMask = '0;
  logic       mIrq = 1'b0;

  always #4 clk = ~clk;

  spi_irq_unit i_spi_irq_unit (
    .clk(clk), .rstN(rstN), .rxLevel(rxLevel), .txLevel(txLevel),
    .overrunPulse(overrunPulse), .timeoutPulse(timeoutPulse),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  function automatic logic [3:0] expRaw(input logic [3:0] rl, input logic [3:0] tl,
                                        input logic [1:0] st);
    return {(tl <= 4'd4), (rl >= 4'd4), st};
  endfunction

  function automatic logic [3:0] expRead(input logic [1:0] a, input logic [3:0] raw,
                                         input logic [3:0] m);
    case (a)
      2'd0: return m;
      2'd1: return raw;
      2'd2: return m & raw;
      default: return 4'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: check registered irq, drive, check read data, advance the model.
  task automatic step(input string req, input logic [3:0] rl, input logic [3:0] tl,
                      input logic ov, input logic to, input logic we,
                      input logic [1:0] a, input logic [3:0] d);
    logic [3:0] raw;
    @(negedge clk);
    chk("R9 irq", {3'b0, irqOut}, {3'b0, mIrq});
    rxLevel = rl; txLevel = tl; overrunPulse = ov; timeoutPulse = to;
    regWrEn = we; regAddr = a; regWrData = d;
    #1;
    raw = expRaw(rl, tl, mSticky);
    chk(req, regRdData, expRead(a, raw, mMask));
    mIrq = |(raw & mMask);
    for (int b = 0; b < 2; b++) begin
      if (b == 0 ? ov : to) mSticky[b] = 1'b1;
      else if (we && a == 2'd3 && d[b]) mSticky[b] = 1'b0;
    end
    if (we && a == 2'd0) mMask = d;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R4 reset state
    step("R4 raw after reset", 4'd0, 4'd0, 0, 0, 0, 2'd1, 4'd0);
    step("R4 mask after reset", 4'd0, 4'd0, 0, 0, 0, 2'd0, 4'd0);
    // R2 / R3 thresholds
    step("R2 rx level 3", 4'd3, 4'd5, 0, 0, 0, 2'd1, 4'd0);
    step("R2 rx level 4", 4'd4, 4'd5, 0, 0, 0, 2'd1, 4'd0);
    step("R3 tx level 4", 4'd0, 4'd4, 0, 0, 0, 2'd1, 4'd0);
    step("R3 tx level 5", 4'd8, 4'd5, 0, 0, 0, 2'd1, 4'd0);
    // R5 set and hold; R8 mask write
    step("R5 overrun pulse", 4'd0, 4'd8, 1, 0, 1, 2'd0, 4'b0011);
    step("R5 overrun held", 4'd0, 4'd8, 0, 0, 0, 2'd1, 4'd0);
    step("R8 masked view", 4'd0, 4'd8, 0, 1, 0, 2'd2, 4'd0);
    // R6 clear of bits 2,3 has no effect; clear bit 0 only
    step("R6 clear upper bits", 4'd5, 4'd0, 0, 0, 1, 2'd3, 4'b1100);
    step("R6 after upper clear", 4'd5, 4'd0, 0, 0, 1, 2'd3, 4'b0001);
    step("R6 bit0 cleared", 4'd5, 4'd0, 0, 0, 0, 2'd1, 4'd0);
    // R7 set and clear collide
    step("R7 collide ovr", 4'd0, 4'd8, 1, 0, 1, 2'd3, 4'b0011);
    step("R7 after collide", 4'd0, 4'd8, 0, 1, 1, 2'd3, 4'b0011);
    step("R7 tmo survives", 4'd0, 4'd8, 0, 0, 0, 2'd1, 4'd0);
    // R1 clear register reads zero; R9 irq with full mask
    step("R1 clear reads 0", 4'd0, 4'd0, 0, 0, 1, 2'd0, 4'b1111);
    step("R1 clear reads 0b", 4'd0, 4'd0, 0, 0, 0, 2'd3, 4'd0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] rl, tl, d;
      logic ov, to, we;
      logic [1:0] a;
      rl = 4'($urandom_range(0, 8));
      tl = 4'($urandom_range(0, 8));
      ov = ($urandom_range(0, 9) == 0);
      to = ($urandom_range(0, 9) == 0);
      we = ($urandom_range(0, 3) == 0);
      a  = 2'($urandom_range(0, 3));
      d  = 4'($urandom_range(0, 15));
      step("R1 R2 R3 R5 R6 R8 random read", rl, tl, ov, to, we, a, d);
    end
    step("R9 final", 4'd0, 4'd8, 0, 0, 0, 2'd1, 4'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule